// File: doc/BRIEF.md
# Three-Wire Gain and Bias Control Register

This block is the digital control front end of a programmable-gain line driver. A host writes a 10-bit control word over a three-wire serial bus made up of a serial clock, a data line and an active-low enable. The bit sent first is the most significant bit. Each bit is captured on a rising edge of the serial clock. When the enable line returns high, the assembled word is checked. A valid word is stored in a pending register.

The pending gain and output-stage current settings do not change the driver at once. They are moved to the active outputs only when the asynchronous transmit-enable input goes from low to high. A host can therefore prepare the next setting during a burst without disturbing that burst. While transmit is off, the active settings are kept.

All four bus and transmit inputs pass through multi-stage synchronizers into the system clock domain. All edges are detected on the synchronized copies. The outputs are:
- the active gain code;
- the active current code;
- an attenuation value in dB derived from the gain code;
- a stage-on indication;
- a sticky flag that marks a word with bad framing bits.

Top module: `gain_bias_ctrl`

## Requirements
- R1: After reset the active gain code is 31, the active current code is 7, the attenuation is 0 dB, stage_on is low and fmt_err is low.
- R2: The word is shifted in most significant bit first, one bit per rising serial clock edge while ser_en_n is low. In the latched word, bits 6..2 are the gain code and bits 9..7 are the current code.
- R3: A rising edge of ser_en_n latches the word into the pending register. While tx_en stays high, the active gain and current outputs do not change.
- R4: A low-to-high transition of tx_en copies the pending gain and current codes to the active outputs.
- R5: atten_db equals 2 x (31 - gain_code), limited to a maximum of 58.
- R6: A latched word whose bit 0 is not 1, or whose bit 1 is not 0, is discarded and leaves the pending register unchanged. Such a word sets fmt_err. fmt_err stays set until the next valid word is latched, and that latch clears it.
- R7: stage_on is high only while tx_en is high and the active current code is nonzero. A current code of 000 keeps both stages off.
- R8: Active settings are retained through a tx_en low period. Re-enabling transmit without a new word restores the same gain and current codes.
- R9: Serial clock edges that occur while ser_en_n is high do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock (asynchronous) |
| ser_dat | input | 1 | Serial bus data, most significant bit first |
| ser_en_n | input | 1 | Serial bus enable, active low; its rising edge latches the word |
| tx_en | input | 1 | Transmit enable (asynchronous, active high) |
| gain_code | output | 5 | Active gain code, 31 is maximum gain |
| cur_code | output | 3 | Active output-stage current code |
| atten_db | output | 6 | Attenuation in dB derived from the active gain code |
| stage_on | output | 1 | Amplifier stages powered |
| fmt_err | output | 1 | Sticky flag for a word with bad framing bits |

## Verification
A wrong value in the pending register stays hidden until the next off-to-on transition of tx_en. At that edge it appears on gain_code, cur_code and atten_db, a few system clocks after the synchronizers settle. The bench therefore checks the outputs after every transmit cycle as well as after every word. A shift register that shifts when it should not, or a lost bit, shows up at once as a framing error on fmt_err. It can also show up as wrong codes at the next transmit enable. A fault in the stage-on logic appears within the synchronizer latency of the tx_en change.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
   localparam int GAIN_W     = 5;
   localparam int CUR_W      = 3;
   localparam int GAIN_LSB   = 2;
   localparam int WORD_W     = GAIN_LSB + GAIN_W + CUR_W;
   localparam int ATTEN_STEP = 2;
   localparam int GAIN_MAX   = (1 << GAIN_W) - 1;
   localparam int ATTEN_W    = $clog2(ATTEN_STEP * GAIN_MAX + 1);

   typedef struct packed {
      logic [CUR_W-1:0]  cur;
      logic [GAIN_W-1:0] gain;
   } gbc_setting_t;

   localparam gbc_setting_t SETTING_RST = '{cur: '1, gain: '1};
endpackage

// File: rtl/gbc_sync.sv
module gbc_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 2) $error("gbc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[gi] <= RST_VAL;
            else if (gi == 0) stg[gi] <= d_i;
            else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gbc_serial_rx.sv
module gbc_serial_rx
   import gbc_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_rise,
   input  logic         en_n_s,
   input  logic         en_rise,
   input  logic         dat_s,
   output gbc_setting_t pend_o,
   output logic         fmt_err_o
);
   logic [WORD_W-1:0] shreg;
   logic              frame_ok;

   assign frame_ok = shreg[0] && !shreg[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (sclk_rise && !en_n_s) begin
         shreg <= {shreg[WORD_W-2:0], dat_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o    <= SETTING_RST;
         fmt_err_o <= 1'b0;
      end else if (en_rise) begin
         if (frame_ok) begin
            pend_o.gain <= shreg[GAIN_LSB +: GAIN_W];
            pend_o.cur  <= shreg[GAIN_LSB+GAIN_W +: CUR_W];
            fmt_err_o   <= 1'b0;
         end else begin
            fmt_err_o   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/gbc_apply.sv
module gbc_apply
   import gbc_pkg::*;
#(
   parameter int ATTEN_MAX = 58,
   parameter bit CLAMP_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_s,
   input  logic               tx_rise,
   input  gbc_setting_t       pend_i,
   output gbc_setting_t       act_o,
   output logic               stage_on_o,
   output logic [ATTEN_W-1:0] atten_o
);
   gbc_setting_t next_act;
   int           raw_db;

   assign next_act = tx_rise ? pend_i : act_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o      <= SETTING_RST;
         stage_on_o <= 1'b0;
      end else begin
         act_o      <= next_act;
         stage_on_o <= tx_s && (next_act.cur != '0);
      end
   end

   assign raw_db = ATTEN_STEP * (GAIN_MAX - int'(act_o.gain));

   generate
      if (CLAMP_EN) begin : g_clamp
         assign atten_o = ATTEN_W'((raw_db > ATTEN_MAX) ? ATTEN_MAX : raw_db);
      end else begin : g_noclamp
         assign atten_o = ATTEN_W'(raw_db);
      end
   endgenerate
endmodule

// File: rtl/gain_bias_ctrl.sv
module gain_bias_ctrl
   import gbc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ATTEN_MAX   = 58,
   parameter bit CLAMP_EN    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ser_clk,
   input  logic         ser_dat,
   input  logic         ser_en_n,
   input  logic         tx_en,
   output logic [4:0]   gain_code,
   output logic [2:0]   cur_code,
   output logic [5:0]   atten_db,
   output logic         stage_on,
   output logic         fmt_err
);
   initial begin
      if (WORD_W != 10) $error("gain_bias_ctrl: word width must be 10");
      if (ATTEN_MAX > ATTEN_STEP * GAIN_MAX) $error("gain_bias_ctrl: ATTEN_MAX out of range");
      if (ATTEN_W != 6) $error("gain_bias_ctrl: attenuation width mismatch");
   end

   localparam int NSIG = 4;
   localparam logic [NSIG-1:0] IDLE = 4'b0100;

   logic [NSIG-1:0] s_now, s_prev;
   logic            sclk_rise, en_rise, tx_rise;
   gbc_setting_t    pend, act;
   logic [ATTEN_W-1:0] atten;

   gbc_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({tx_en, ser_en_n, ser_dat, ser_clk}),
      .q_o(s_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= IDLE;
      else        s_prev <= s_now;
   end

   assign sclk_rise = s_now[0] && !s_prev[0];
   assign en_rise   = s_now[2] && !s_prev[2];
   assign tx_rise   = s_now[3] && !s_prev[3];

   gbc_serial_rx u_rx (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise(sclk_rise), .en_n_s(s_now[2]), .en_rise(en_rise),
      .dat_s(s_now[1]),
      .pend_o(pend), .fmt_err_o(fmt_err)
   );

   gbc_apply #(.ATTEN_MAX(ATTEN_MAX), .CLAMP_EN(CLAMP_EN)) u_apply (
      .clk(clk), .rst_n(rst_n),
      .tx_s(s_now[3]), .tx_rise(tx_rise),
      .pend_i(pend), .act_o(act),
      .stage_on_o(stage_on), .atten_o(atten)
   );

   assign gain_code = act.gain;
   assign cur_code  = act.cur;
   assign atten_db  = atten;
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker
   import gbc_pkg::*;
#(
   parameter int ATTEN_MAX = 58
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tx_rise,
   input logic               en_rise,
   input gbc_setting_t       pend,
   input logic [GAIN_W-1:0]  gain_code,
   input logic [CUR_W-1:0]   cur_code,
   input logic [ATTEN_W-1:0] atten_db,
   input logic               stage_on,
   input logic               fmt_err
);
   // R3
   hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rise |=> ($stable(gain_code) && $stable(cur_code)));

   // R4
   apply_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rise |=> (gain_code == $past(pend.gain) && cur_code == $past(pend.cur)));

   // R5
   atten_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_db <= ATTEN_MAX) && !atten_db[0]);

   // R6
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fmt_err) |-> $past(en_rise));

   // R7
   off_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_code == '0) |-> !stage_on);
endmodule

bind gain_bias_ctrl gbc_checker #(.ATTEN_MAX(ATTEN_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_rise(tx_rise), .en_rise(en_rise),
   .pend(pend), .gain_code(gain_code), .cur_code(cur_code),
   .atten_db(atten_db), .stage_on(stage_on), .fmt_err(fmt_err)
);

// File: tb/tb_gain_bias_ctrl.sv
module tb_gain_bias_ctrl;
   localparam int CLK_P = 10;
   localparam int HOLD  = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1, tx_en = 1'b0;
   logic [4:0] gain_code;
   logic [2:0] cur_code;
   logic [5:0] atten_db;
   logic       stage_on, fmt_err;

   int checks = 0, errors = 0;
   logic [4:0] m_pg = 5'd31, m_ag = 5'd31;
   logic [2:0] m_pc = 3'd7,  m_ac = 3'd7;
   logic       m_err = 1'b0, m_tx = 1'b0;
   bit         done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gain_bias_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_en_n(ser_en_n), .tx_en(tx_en), .gain_code(gain_code),
      .cur_code(cur_code), .atten_db(atten_db), .stage_on(stage_on),
      .fmt_err(fmt_err)
   );

   function automatic int exp_atten(input logic [4:0] g);
      int v = 2 * (31 - int'(g));
      return (v > 58) ? 58 : v;
   endfunction

   function automatic bit frame_ok(input logic [9:0] w);
      return w[0] && !w[1];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic check_all(input string req);
      chk({req, " gain"}, gain_code, m_ag);
      chk({req, " cur"}, cur_code, m_ac);
      chk({req, " atten"}, atten_db, exp_atten(m_ag));
      chk({req, " stage_on"}, stage_on, m_tx && (m_ac != 0));
      chk({req, " fmt_err"}, fmt_err, m_err);
   endtask

   task automatic pulse_sclk();
      ser_clk = 1'b1; wait_clk(HOLD);
      ser_clk = 1'b0; wait_clk(HOLD);
   endtask

   task automatic send_word(input logic [9:0] w);
      ser_en_n = 1'b0; wait_clk(HOLD);
      for (int b = 9; b >= 0; b--) begin
         ser_dat = w[b];
         wait_clk(HOLD);
         pulse_sclk();
      end
      ser_en_n = 1'b1; wait_clk(6);
      if (frame_ok(w)) begin
         m_pg = w[6:2]; m_pc = w[9:7]; m_err = 1'b0;
      end else begin
         m_err = 1'b1;
      end
   endtask

   task automatic set_tx(input logic v);
      if (v && !m_tx) begin m_ag = m_pg; m_ac = m_pc; end
      tx_en = v; m_tx = v;
      wait_clk(6);
   endtask

   function automatic logic [9:0] mk(input logic [2:0] c, input logic [4:0] g);
      return {c, g, 2'b01};
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      // R1 reset state
      check_all("R1");
      chk("R1 atten zero", atten_db, 0);

      // R2 R4 field positions and MSB-first order
      send_word(mk(3'b101, 5'b10011));
      set_tx(1'b1);
      check_all("R2");
      chk("R2 gain field", gain_code, 19);
      chk("R2 cur field", cur_code, 5);

      // R3 new word while transmitting does not take effect
      send_word(mk(3'b011, 5'b00100));
      check_all("R3");
      chk("R3 held gain", gain_code, 19);
      set_tx(1'b0);
      set_tx(1'b1);
      check_all("R4");
      chk("R4 applied gain", gain_code, 4);

      // R5 clamp corners
      send_word(mk(3'b111, 5'b00000));
      set_tx(1'b0); set_tx(1'b1);
      chk("R5 gain0 clamp", atten_db, 58);
      send_word(mk(3'b111, 5'b00010));
      set_tx(1'b0); set_tx(1'b1);
      chk("R5 gain2", atten_db, 58);
      send_word(mk(3'b111, 5'b00011));
      set_tx(1'b0); set_tx(1'b1);
      chk("R5 gain3", atten_db, 56);

      // R6 bad frame: bit1 set, then bit0 clear
      send_word({3'b001, 5'b11111, 2'b11});
      check_all("R6 bad bit1");
      send_word({3'b001, 5'b11111, 2'b00});
      set_tx(1'b0); set_tx(1'b1);
      check_all("R6 discarded");
      send_word(mk(3'b110, 5'b01010));
      chk("R6 cleared", fmt_err, 0);

      // R7 zero current keeps stages off
      send_word(mk(3'b000, 5'b01010));
      set_tx(1'b0); set_tx(1'b1);
      chk("R7 zero current", stage_on, 0);
      check_all("R7");

      // R8 retention across disable
      send_word(mk(3'b010, 5'b11000));
      set_tx(1'b0); set_tx(1'b1);
      set_tx(1'b0);
      check_all("R8 off");
      set_tx(1'b1);
      chk("R8 gain kept", gain_code, 24);
      chk("R8 cur kept", cur_code, 2);

      // R9 clock edges while enable high are ignored
      send_word(mk(3'b010, 5'b00101));
      ser_dat = 1'b1;
      for (int k = 0; k < 4; k++) pulse_sclk();
      ser_en_n = 1'b0; wait_clk(HOLD);
      ser_en_n = 1'b1; wait_clk(6);
      set_tx(1'b0); set_tx(1'b1);
      check_all("R9");
      chk("R9 no frame error", fmt_err, 0);

      // random mix
      for (int it = 0; it < 40; it++) begin
         logic [9:0] w;
         w = 10'($urandom);
         if ($urandom_range(0, 3) != 0) w[1:0] = 2'b01;
         send_word(w);
         if ($urandom_range(0, 1) == 1) set_tx(~m_tx);
         check_all("R2 R4 R6 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule